// File: doc/BRIEF.md
# Adaptive Boost Headroom Controller with LED String Fault Detection

This block closes the digital side of an adaptive supply loop for a bank of LED current sinks. Each sink reports three cathode comparator flags: below the low threshold (0.9 V), above the middle threshold (1.9 V) and above the high threshold (6 V). From these flags the block steps an 8-bit target code for the boost converter's voltage DAC. The aim is for the weakest active string to sit just at the low threshold, so the supply is no higher than needed.

Channels that start-up detection found tied to ground are left out of the loop and their sinks stay off. Two LED faults are found while the converter is in its normal run state. An open string stays low even with the target at full scale. A shorted string shows excess headroom while another string is in the normal band. A faulty string is latched off, dropped from the loop and reported on a shared fault line, and it stays so until a clear pulse.

Two states drive the block. In IDLE (run low) the target is held at its entry value. IDLE goes to TRACK on run high and TRACK goes back to IDLE on run low. In TRACK an evaluation takes place every 256 clocks. Each evaluation takes one of three steps: UP, DOWN or HOLD.

Top module: `hdr_ctrl`

## Requirements
- R1: In TRACK, if any monitored channel showed `below_lo`=1 on every PWM-on sample of an evaluation window, the target rises by one code at the end of that window; between evaluations the target does not change.
- R2: In TRACK, if every monitored channel showed `below_lo`=0 on all its PWM-on samples of the window, the target falls by one code at the end of the window.
- R3: If no monitored channel is stuck low but some monitored channel's `below_lo` took both values within the window (touching the threshold), the target holds.
- R4: A channel with its `grounded` bit set has `sink_en` bit 0 and its flags have no effect on the target or on fault detection.
- R5: A monitored channel that is stuck low for a whole window while the target is 255 counts as open; on the 4th consecutive such evaluation `open_flt` for that channel is set, its `sink_en` bit goes to 0 and it leaves the loop.
- R6: A monitored channel whose last PWM-on sample had `above_hi`=1 counts as shorted only when another monitored channel's last sample had `below_lo`=0 and `above_mid`=0; after 4 consecutive such evaluations `short_flt` is set and the channel's sink is disabled.
- R7: A one-cycle `flt_clr` pulse clears all latched open and short faults, and the affected `sink_en` bits return to 1 on the next cycle.
- R8: After reset and whenever `run` is low the target is 224 (0.88 of full scale, truncated), and TRACK starts from that value; the target saturates at 0 and 255.
- R9: Comparator flags are sampled only while `pwm_on` is 1; a window with no such sample leaves the target and fault counts unchanged in effect (hold, no candidates).
- R10: `led_fault` is 1 exactly when any channel has a latched open or short fault; no fault is counted while `run` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Converter is in its normal run state |
| pwm_on | input | 1 | Dimming PWM is in its on phase |
| grounded | input | NCH | Channel found tied to ground at start-up |
| below_lo | input | NCH | Cathode below low threshold |
| above_mid | input | NCH | Cathode above middle threshold |
| above_hi | input | NCH | Cathode above high threshold |
| flt_clr | input | 1 | One-cycle pulse clearing latched faults |
| tgt_code | output | DW | Boost voltage DAC target code |
| sink_en | output | NCH | Per-channel current sink enable |
| open_flt | output | NCH | Latched open-string fault |
| short_flt | output | NCH | Latched shorted-string fault |
| led_fault | output | 1 | Any LED fault latched |

## Verification
A wrong step decision shows on `tgt_code` at the first evaluation edge: a code one off in the wrong direction appears 256 clocks after the inputs are applied. A stale window accumulator or a miscounted fault counter shows later. `open_flt` or `short_flt` then rises one evaluation early or late, and `sink_en` and `led_fault` change in the same cycle. The checks therefore sample one clock after each evaluation edge and read the target, the fault bits, the sink mask and the fault line together.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
    typedef enum logic [0:0] {S_IDLE, S_TRACK} hdr_state_t;
    typedef enum logic [1:0] {D_HOLD, D_UP, D_DOWN} hdr_dir_t;
endpackage

// File: rtl/hdr_window.sv
module hdr_window #(
    parameter int WIN = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic eval
);
    localparam int CW = $clog2(WIN);
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!active)    cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign eval = active && (cnt == LAST);

    AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == '0)); // R1
endmodule

// File: rtl/hdr_chan_flt.sv
module hdr_chan_flt #(
    parameter int FLT_HITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic track,
    input  logic eval,
    input  logic clear,
    input  logic open_cand,
    input  logic short_cand,
    output logic open_flt,
    output logic short_flt
);
    localparam int CW = $clog2(FLT_HITS + 1);
    localparam logic [CW-1:0] FINAL = CW'(FLT_HITS - 1);

    logic [CW-1:0] ocnt, scnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ocnt <= '0; scnt <= '0; open_flt <= 1'b0; short_flt <= 1'b0;
        end else if (clear) begin
            ocnt <= '0; scnt <= '0; open_flt <= 1'b0; short_flt <= 1'b0;
        end else if (!track) begin
            ocnt <= '0; scnt <= '0;
        end else if (eval) begin
            if (open_cand) begin
                if (ocnt == FINAL) begin open_flt <= 1'b1; ocnt <= '0; end
                else ocnt <= ocnt + 1'b1;
            end else ocnt <= '0;
            if (short_cand) begin
                if (scnt == FINAL) begin short_flt <= 1'b1; scnt <= '0; end
                else scnt <= scnt + 1'b1;
            end else scnt <= '0;
        end
    end

    AST_FLT_ON_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(open_flt) || $rose(short_flt)) |-> $past(eval && track)); // R5
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!open_flt && !short_flt)); // R7
endmodule

// File: rtl/hdr_ctrl.sv
module hdr_ctrl
    import hdr_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int DW       = 8,
    parameter int WIN      = 256,
    parameter int FLT_HITS = 4,
    parameter int INIT_PCT = 88
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           pwm_on,
    input  logic [NCH-1:0] grounded,
    input  logic [NCH-1:0] below_lo,
    input  logic [NCH-1:0] above_mid,
    input  logic [NCH-1:0] above_hi,
    input  logic           flt_clr,
    output logic [DW-1:0]  tgt_code,
    output logic [NCH-1:0] sink_en,
    output logic [NCH-1:0] open_flt,
    output logic [NCH-1:0] short_flt,
    output logic           led_fault
);
    localparam logic [DW-1:0] CODE_MAX  = {DW{1'b1}};
    localparam int            INIT_INT  = ((2**DW - 1) * INIT_PCT) / 100;
    localparam logic [DW-1:0] CODE_INIT = DW'(INIT_INT);

    hdr_state_t st, st_nxt;
    hdr_dir_t   dir;
    logic       tracking, eval;

    logic [NCH-1:0] saw_lo, saw_clear, last_lo, last_mid, last_hi;
    logic           any_smp;
    logic [NCH-1:0] mon, stuck_lo, touch, band, open_cand, short_cand;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            S_IDLE:  if (run)  st_nxt = S_TRACK;
            S_TRACK: if (!run) st_nxt = S_IDLE;
        endcase
    end

    assign tracking = (st == S_TRACK) && run;

    hdr_window #(.WIN(WIN)) u_win (
        .clk(clk), .rst_n(rst_n), .active(tracking), .eval(eval)
    );

    // window sample accumulation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saw_lo <= '0; saw_clear <= '0; any_smp <= 1'b0;
            last_lo <= '0; last_mid <= '0; last_hi <= '0;
        end else if (!tracking || eval) begin
            saw_lo <= '0; saw_clear <= '0; any_smp <= 1'b0;
        end else if (pwm_on) begin
            saw_lo    <= saw_lo | below_lo;
            saw_clear <= saw_clear | ~below_lo;
            any_smp   <= 1'b1;
            last_lo   <= below_lo;
            last_mid  <= above_mid;
            last_hi   <= above_hi;
        end
    end

    assign mon      = ~grounded & ~open_flt & ~short_flt;
    assign stuck_lo = mon & saw_lo & ~saw_clear;
    assign touch    = mon & saw_lo & saw_clear;
    assign band     = mon & ~last_lo & ~last_mid & {NCH{any_smp}};

    always_comb begin
        if (!any_smp || (mon == '0)) dir = D_HOLD;
        else if (|stuck_lo)          dir = D_UP;
        else if (|touch)             dir = D_HOLD;
        else                         dir = D_DOWN;
    end

    assign open_cand = stuck_lo & {NCH{tgt_code == CODE_MAX}};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [NCH-1:0] others;
        assign others        = band & ~(NCH'(1) << c);
        assign short_cand[c] = mon[c] & any_smp & last_hi[c] & (|others);

        hdr_chan_flt #(.FLT_HITS(FLT_HITS)) u_flt (
            .clk(clk), .rst_n(rst_n), .track(tracking), .eval(eval),
            .clear(flt_clr), .open_cand(open_cand[c]),
            .short_cand(short_cand[c]),
            .open_flt(open_flt[c]), .short_flt(short_flt[c])
        );
    end

    // output process: target code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             tgt_code <= CODE_INIT;
        else if (!tracking)     tgt_code <= CODE_INIT;
        else if (eval) begin
            unique case (dir)
                D_UP:   if (tgt_code != CODE_MAX) tgt_code <= tgt_code + 1'b1;
                D_DOWN: if (tgt_code != '0)       tgt_code <= tgt_code - 1'b1;
                default: ;
            endcase
        end
    end

    assign sink_en   = mon;
    assign led_fault = |(open_flt | short_flt);

    AST_IDLE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (tgt_code == CODE_INIT)); // R8
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tracking && !eval) |=> $stable(tgt_code)); // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        tracking |=> (tgt_code == $past(tgt_code) ||
                      tgt_code == DW'($past(tgt_code) + 1'b1) ||
                      tgt_code == DW'($past(tgt_code) - 1'b1))); // R8
    AST_NO_FLT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !flt_clr) |=> $stable(open_flt | short_flt)); // R10
endmodule

// File: tb/sim_hdr_ctrl.sv
module sim_hdr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int WIN = 256;

    logic clk = 1'b0;
    logic rst_n, run, pwm_on, flt_clr;
    logic [NCH-1:0] grounded, below_lo, above_mid, above_hi;
    logic [7:0] tgt_code;
    logic [NCH-1:0] sink_en, open_flt, short_flt;
    logic led_fault;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .pwm_on(pwm_on),
        .grounded(grounded), .below_lo(below_lo), .above_mid(above_mid),
        .above_hi(above_hi), .flt_clr(flt_clr), .tgt_code(tgt_code),
        .sink_en(sink_en), .open_flt(open_flt), .short_flt(short_flt),
        .led_fault(led_fault)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run = 1'b0; pwm_on = 1'b1; flt_clr = 1'b0;
        grounded = '0; below_lo = '0; above_mid = '1; above_hi = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // start TRACK and wait until n evaluations are done, sampling 1 clock after
    task automatic go(input int n);
        run = 1'b1;
        repeat (n*WIN + 2) @(posedge clk);
        #1;
    endtask

    task automatic more(input int m);
        repeat (m*WIN) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R8 reset target", tgt_code, 224);
        chk("R4 reset sink_en", sink_en, 4'b1111);
        chk("R10 reset led_fault", led_fault, 0);
    endtask

    task automatic t_up();
        do_reset();
        below_lo = 4'b0001;
        go(3);
        chk("R1 raise 3 steps", tgt_code, 227);
        chk("R10 no fault while raising", led_fault, 0);
    endtask

    task automatic t_down();
        do_reset();
        go(5);
        chk("R2 lower 5 steps", tgt_code, 219);
    endtask

    task automatic t_touch();
        do_reset();
        run = 1'b1;
        for (int i = 0; i < 3*WIN + 2; i++) begin
            @(negedge clk);
            below_lo[1] = ~below_lo[1];
        end
        chk("R3 hold when touching", tgt_code, 224);
    endtask

    task automatic t_grounded();
        do_reset();
        grounded = 4'b0100;
        below_lo = 4'b0100;
        above_hi = 4'b0100;
        go(2);
        chk("R4 grounded ignored target", tgt_code, 222);
        chk("R4 grounded sink off", sink_en, 4'b1011);
        chk("R4 grounded no fault", led_fault, 0);
    endtask

    task automatic t_pwm_off();
        do_reset();
        pwm_on = 1'b0;
        below_lo = 4'b0001;
        go(3);
        chk("R9 pwm off holds", tgt_code, 224);
        pwm_on = 1'b1;
        more(1);
        chk("R9 pwm on resumes", tgt_code, 225);
    endtask

    task automatic t_idle();
        do_reset();
        below_lo = 4'b0001;
        repeat (3*WIN) @(posedge clk);
        #1;
        chk("R8 idle keeps init", tgt_code, 224);
        go(2);
        chk("R1 raise after entry", tgt_code, 226);
        run = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R8 run low restores init", tgt_code, 224);
    endtask

    task automatic t_open();
        do_reset();
        below_lo = 4'b1000;
        go(33);
        chk("R8 saturate at 255", tgt_code, 255);
        chk("R5 open not yet", open_flt, 0);
        more(1);
        chk("R5 open after 3 at max", open_flt, 0);
        more(1);
        chk("R5 open latched", open_flt, 4'b1000);
        chk("R5 open sink off", sink_en, 4'b0111);
        chk("R10 led_fault on open", led_fault, 1);
        more(1);
        chk("R5 open channel dropped", tgt_code, 254);
        flt_clr = 1'b1;
        @(posedge clk); #1;
        flt_clr = 1'b0;
        chk("R7 clear open", open_flt, 0);
        chk("R7 clear sink back", sink_en, 4'b1111);
        chk("R10 led_fault cleared", led_fault, 0);
    endtask

    task automatic t_short_neg();
        do_reset();
        above_hi = 4'b0001;
        go(6);
        chk("R6 no short without band", short_flt, 0);
        chk("R2 lower 6 steps", tgt_code, 218);
    endtask

    task automatic t_short();
        do_reset();
        above_hi  = 4'b0001;
        above_mid = 4'b1101;
        go(3);
        chk("R6 short not yet", short_flt, 0);
        more(1);
        chk("R6 short latched", short_flt, 4'b0001);
        chk("R6 short sink off", sink_en, 4'b1110);
        chk("R10 led_fault on short", led_fault, 1);
        run = 1'b0;
        repeat (3*WIN) @(posedge clk); #1;
        chk("R10 fault kept in idle", short_flt, 4'b0001);
        flt_clr = 1'b1;
        @(posedge clk); #1;
        flt_clr = 1'b0;
        chk("R7 clear short", sink_en, 4'b1111);
    endtask

    initial begin
        t_reset();
        t_up();
        t_down();
        t_touch();
        t_grounded();
        t_pwm_off();
        t_idle();
        t_open();
        t_short_neg();
        t_short();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule